// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a combinational saturating arithmetic unit for integer datapaths. A 4-bit opcode selects the operation: signed and unsigned add and subtract that clamp instead of wrapping, a signed doubling, and clamping of a value to a chosen bit position. The position clamp comes in signed and unsigned forms, each applied either to the whole word or to the two halfwords on their own. A wrap-around add is also provided that only reports signed overflow. The result appears in the same cycle as the operands.

Alongside the datapath sits a sticky saturation flag. Any operation that clamps while the valid strobe is high sets the flag on the next clock edge. The flag stays set until the clear input is raised, and clear wins over a set in the same cycle. The data width is a parameter (W, default 32, even). The position field is $clog2(W) bits wide.

Top module: `satUnit`

## Requirements
- R1: Opcode 0 (signed clamp add) returns opA+opB. When both operands share a sign and the sum's sign differs, it returns the largest positive value 2^(W-1)-1 if opA is non-negative and the most negative value -2^(W-1) if opA is negative, and reports a clamp.
- R2: Opcode 1 (signed clamp subtract) returns opA-opB. When the operand signs differ and the difference's sign differs from opA, it clamps to the extreme matching opA's sign and reports a clamp.
- R3: Opcode 9 (wrap add) always returns the W-bit wrapped sum. It reports a clamp exactly when the signed sum overflows.
- R4: Opcode 2 (doubling) takes signed opA. It returns 2^(W-1)-1 when opA >= 2^(W-2) and -2^(W-1) when opA <= -2^(W-2), reporting a clamp in both cases. Otherwise it returns opA shifted left by one.
- R5: Opcode 3 (unsigned add) returns all ones with a clamp when the sum carries out. Opcode 4 (unsigned subtract) returns zero with a clamp when opB exceeds opA. Otherwise each returns the plain sum or difference.
- R6: Opcode 5 (signed position clamp) takes n = satPos and mask = 2^n-1. Let t = opA arithmetically shifted right by n. If t > 0 the result is mask; if t < -1 the result is ~mask; in both cases a clamp is reported. Otherwise the result is opA.
- R7: Opcode 6 (unsigned position clamp) takes signed opA and mask = 2^satPos-1. A negative opA gives 0, and a value above mask gives mask; both report a clamp. Otherwise the result is opA.
- R8: Opcodes 7 and 8 apply the rules of R6 and R7 to each sign-extended halfword of opA (bits W/2-1:0 and W-1:W/2). Each lane result is truncated back to W/2 bits and placed in its own half. A clamp in either lane reports a clamp.
- R9: The sticky flag becomes 1 on the clock edge after a cycle with valid high and a reported clamp. It holds its value on every other edge. A clamp while valid is low leaves it unchanged.
- R10: With clearFlag high, the flag is 0 after the edge, even if a clamp is set in the same cycle.
- R11: Opcodes 10 to 15 return zero, report no clamp and leave the flag unchanged.
- R12: While rstN is low the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rstN | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Lets a clamp of this cycle set the flag |
| clearFlag | input | 1 | Clears the sticky flag, priority over set |
| opcode | input | 4 | Operation select |
| opA | input | W | First operand or value to clamp |
| opB | input | W | Second operand |
| satPos | input | $clog2(W) | Bit position for the position clamps |
| result | output | W | Combinational result |
| stickyFlag | output | 1 | Sticky saturation flag |

## Verification
On every cycle, the assertions check the flag's sequencing: clear beats set, the flag holds, and only a valid clamp can raise it. They also check range properties of the result. A position-clamped result stays inside its window, unsigned add and subtract never wrap, doubling keeps the sign, each halfword lane result fits its half, and unused codes stay quiet. The exact clamp values and the boundaries where clamping starts need the bench's scenarios. That covers the threshold of the doubling, the lane packing and the overflow rules.

// File: rtl/satPkg.sv
package satPkg;

  typedef enum logic [3:0] {
    OP_ADD_SS   = 4'd0,
    OP_SUB_SS   = 4'd1,
    OP_DBL_SS   = 4'd2,
    OP_ADD_US   = 4'd3,
    OP_SUB_US   = 4'd4,
    OP_POS_S    = 4'd5,
    OP_POS_U    = 4'd6,
    OP_POS_S2   = 4'd7,
    OP_POS_U2   = 4'd8,
    OP_ADD_WRAP = 4'd9
  } satOpE;

  // One strobe per operation; at most one is high.
  typedef struct packed {
    logic addSigned;
    logic subSigned;
    logic dblSigned;
    logic addUns;
    logic subUns;
    logic posSigned;
    logic posUns;
    logic posSigned2;
    logic posUns2;
    logic addWrap;
  } satStrobeT;

endpackage

// File: rtl/satPosClamp.sv
// Clamps a W-bit value to bit position pos, signed or unsigned.
module satPosClamp #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          isSigned,
  output logic [W-1:0]  out,
  output logic          hit
);
  localparam int MSB = W - 1;

  logic [W-1:0] mask;
  logic [W-1:0] top;
  logic         topPos;
  logic         topNeg;
  logic         isNeg;
  logic         over;

  always_comb begin
    mask   = (W'(1) << pos) - W'(1);
    top    = W'($signed(val) >>> pos);
    topPos = !top[MSB] && (top != '0);
    topNeg = top[MSB] && (top != '1);
    isNeg  = val[MSB];
    over   = !isNeg && (val > mask);
    if (isSigned) begin
      hit = topPos || topNeg;
      if (topPos)      out = mask;
      else if (topNeg) out = ~mask;
      else             out = val;
    end else begin
      hit = isNeg || over;
      if (isNeg)       out = '0;
      else if (over)   out = mask;
      else             out = val;
    end
  end
endmodule

// File: rtl/satDatapath.sv
module satDatapath
  import satPkg::*;
#(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  satStrobeT     strobes,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [PW-1:0] satPos,
  output logic [W-1:0]  result,
  output logic          clampHit
);
  localparam int MSB = W - 1;
  localparam int H   = W / 2;
  localparam logic [W-1:0] SMAX   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] DBL_HI = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] DBL_LO = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   sumWide;
  logic [W:0]   diffWide;
  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         addOvf;
  logic         subOvf;
  logic         carryOut;
  logic         borrow;
  logic [W-1:0] limA;
  logic         dblHigh;
  logic         dblLow;

  always_comb begin
    sumWide  = {1'b0, opA} + {1'b0, opB};
    diffWide = {1'b0, opA} - {1'b0, opB};
    sum      = sumWide[W-1:0];
    diff     = diffWide[W-1:0];
    carryOut = sumWide[W];
    borrow   = diffWide[W];
    addOvf   = (opA[MSB] ~^ opB[MSB]) && (sum[MSB] ^ opA[MSB]);
    subOvf   = (opA[MSB] ^ opB[MSB]) && (diff[MSB] ^ opA[MSB]);
    limA     = opA[MSB] ? SMIN : SMAX;
    dblHigh  = $signed(opA) >= $signed(DBL_HI);
    dblLow   = $signed(opA) <= $signed(DBL_LO);
  end

  // Full-width position clamp
  logic [W-1:0] fullOut;
  logic         fullHit;

  satPosClamp #(.W(W), .PW(PW)) uFullClamp (
    .val      (opA),
    .pos      (satPos),
    .isSigned (strobes.posSigned),
    .out      (fullOut),
    .hit      (fullHit)
  );

  // Halfword lanes
  logic [H-1:0] laneRes [2];
  logic [1:0]   laneHit;

  for (genvar gi = 0; gi < 2; gi++) begin : gLane
    logic [W-1:0] laneIn;
    logic [W-1:0] laneFull;
    assign laneIn = {{H{opA[gi*H+H-1]}}, opA[gi*H +: H]};

    satPosClamp #(.W(W), .PW(PW)) uLaneClamp (
      .val      (laneIn),
      .pos      (satPos),
      .isSigned (strobes.posSigned2),
      .out      (laneFull),
      .hit      (laneHit[gi])
    );
    assign laneRes[gi] = laneFull[H-1:0];

    AST_LANE_FITS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.posSigned2 || strobes.posUns2) |->
        (laneFull == {{H{laneFull[H-1]}}, laneFull[H-1:0]})) // R8
      else $error("lane result exceeds its half");
  end

  always_comb begin
    result   = '0;
    clampHit = 1'b0;
    if (strobes.addSigned) begin
      result   = addOvf ? limA : sum;
      clampHit = addOvf;
    end else if (strobes.subSigned) begin
      result   = subOvf ? limA : diff;
      clampHit = subOvf;
    end else if (strobes.addWrap) begin
      result   = sum;
      clampHit = addOvf;
    end else if (strobes.dblSigned) begin
      if (dblHigh)     result = SMAX;
      else if (dblLow) result = SMIN;
      else             result = {opA[W-2:0], 1'b0};
      clampHit = dblHigh || dblLow;
    end else if (strobes.addUns) begin
      result   = carryOut ? '1 : sum;
      clampHit = carryOut;
    end else if (strobes.subUns) begin
      result   = borrow ? '0 : diff;
      clampHit = borrow;
    end else if (strobes.posSigned || strobes.posUns) begin
      result   = fullOut;
      clampHit = fullHit;
    end else if (strobes.posSigned2 || strobes.posUns2) begin
      result   = {laneRes[1], laneRes[0]};
      clampHit = |laneHit;
    end
  end

  // Window for range assertions, built apart from the clamp lanes
  logic [W-1:0] posMask;
  assign posMask = ~('1 << satPos);

  AST_USAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.posUns |-> (result <= posMask)) // R7
    else $error("unsigned position clamp out of range");

  AST_SSAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.posSigned |->
      (($signed(result) <= $signed(posMask)) && ($signed(result) >= $signed(~posMask)))) // R6
    else $error("signed position clamp out of range");

  AST_UADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addUns |-> (result >= opA)) // R5
    else $error("unsigned add wrapped");

  AST_USUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.subUns |-> (result <= opA)) // R5
    else $error("unsigned subtract wrapped");

  AST_DBL_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dblSigned |-> (result[MSB] == opA[MSB])) // R4
    else $error("doubling changed sign");

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |-> ((result == '0) && !clampHit)) // R11
    else $error("idle datapath not quiet");
endmodule

// File: rtl/satCtrl.sv
module satCtrl
  import satPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       valid,
  input  logic       clearFlag,
  input  logic [3:0] opcode,
  input  logic       clampHit,
  output satStrobeT  strobes,
  output logic       stickyFlag
);
  always_comb begin
    strobes = '0;
    case (opcode)
      OP_ADD_SS:   strobes.addSigned  = 1'b1;
      OP_SUB_SS:   strobes.subSigned  = 1'b1;
      OP_DBL_SS:   strobes.dblSigned  = 1'b1;
      OP_ADD_US:   strobes.addUns     = 1'b1;
      OP_SUB_US:   strobes.subUns     = 1'b1;
      OP_POS_S:    strobes.posSigned  = 1'b1;
      OP_POS_U:    strobes.posUns     = 1'b1;
      OP_POS_S2:   strobes.posSigned2 = 1'b1;
      OP_POS_U2:   strobes.posUns2    = 1'b1;
      OP_ADD_WRAP: strobes.addWrap    = 1'b1;
      default:     strobes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stickyFlag <= 1'b0;
    else if (clearFlag)         stickyFlag <= 1'b0;
    else if (valid && clampHit) stickyFlag <= 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clearFlag |=> !stickyFlag) // R10
    else $error("clear did not win");

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stickyFlag && !clearFlag) |=> stickyFlag) // R9
    else $error("flag dropped without clear");

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!stickyFlag && !valid) |=> !stickyFlag) // R9
    else $error("flag rose without valid");

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (valid && clampHit && !clearFlag) |=> stickyFlag) // R9
    else $error("clamp did not set flag");
endmodule

// File: rtl/satUnit.sv
module satUnit
  import satPkg::*;
#(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid,
  input  logic          clearFlag,
  input  logic [3:0]    opcode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [PW-1:0] satPos,
  output logic [W-1:0]  result,
  output logic          stickyFlag
);
  satStrobeT strobes;
  logic      clampHit;

  satCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .valid      (valid),
    .clearFlag  (clearFlag),
    .opcode     (opcode),
    .clampHit   (clampHit),
    .strobes    (strobes),
    .stickyFlag (stickyFlag)
  );

  satDatapath #(.W(W), .PW(PW)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .satPos   (satPos),
    .result   (result),
    .clampHit (clampHit)
  );
endmodule

// File: tb/satUnit_tb.sv
module satUnit_tb;
  localparam int W  = 8;
  localparam int PW = 3;
  localparam int H  = W / 2;
  localparam int SMAXI = (1 << (W-1)) - 1;
  localparam int SMINI = -(1 << (W-1));
  localparam int ALL   = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          valid = 1'b0;
  logic          clearFlag = 1'b0;
  logic [3:0]    opcode = '0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic [PW-1:0] satPos = '0;
  logic [W-1:0]  result;
  logic          stickyFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  satUnit #(.W(W), .PW(PW)) u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .clearFlag(clearFlag),
    .opcode(opcode), .opA(opA), .opB(opB), .satPos(satPos),
    .result(result), .stickyFlag(stickyFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h pos %0d)",
               req, act, exp, opcode, opA, opB, satPos);
    end
  endtask

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits-1))) ? v - (1 << bits) : v;
  endfunction

  function automatic int ssatRef(input int v, input int n);
    int top = v >>> n;
    int mask = (1 << n) - 1;
    if (top > 0)  return mask;
    if (top < -1) return ~mask;
    return v;
  endfunction

  function automatic int usatRef(input int v, input int n);
    int mask = (1 << n) - 1;
    if (v < 0)    return 0;
    if (v > mask) return mask;
    return v;
  endfunction

  function automatic int clampSigned(input int s);
    if (s > SMAXI) return SMAXI;
    if (s < SMINI) return SMINI;
    return s;
  endfunction

  function automatic int refRes(input int op, input int a, input int b, input int n);
    int sa = sx(a, W);
    int sb = sx(b, W);
    int r;
    case (op)
      0: r = clampSigned(sa + sb);
      1: r = clampSigned(sa - sb);
      2: r = (sa >= (1 << (W-2))) ? SMAXI : (sa <= -(1 << (W-2))) ? SMINI : sa * 2;
      3: r = (a + b > ALL) ? ALL : a + b;
      4: r = (b > a) ? 0 : a - b;
      5: r = ssatRef(sa, n);
      6: r = usatRef(sa, n);
      7: r = (ssatRef(sx(a & 15, H), n) & 15) | ((ssatRef(sx(a >> H, H), n) & 15) << H);
      8: r = (usatRef(sx(a & 15, H), n) & 15) | ((usatRef(sx(a >> H, H), n) & 15) << H);
      9: r = a + b;
      default: r = 0;
    endcase
    return r & ALL;
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R8";
      9: return "R3";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b, input int n,
                       input bit v, input bit clr);
    @(negedge clk);
    opcode = 4'(op); opA = W'(a); opB = W'(b); satPos = PW'(n);
    valid = v; clearFlag = clr;
    @(negedge clk);
    valid = 1'b0; clearFlag = 1'b0;
  endtask

  task automatic setFlag();
    apply(0, 8'h70, 8'h70, 0, 1'b1, 1'b0);
  endtask

  task automatic clearOnly();
    apply(10, 0, 0, 0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 flag in reset", int'(stickyFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 flag after reset", int'(stickyFlag), 0);

    // Result sweeps, valid low so the flag is not disturbed
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op == 1 || op == 3 || op == 4 || op == 9) begin
        for (int a = 0; a <= ALL; a++) begin
          for (int b = 0; b <= ALL; b++) begin
            opcode = 4'(op); opA = W'(a); opB = W'(b); satPos = '0;
            #1ns;
            chk(reqOf(op), int'(result), refRes(op, a, b, 0));
          end
        end
      end else if (op >= 5 && op <= 8) begin
        for (int n = 0; n < W; n++) begin
          for (int a = 0; a <= ALL; a++) begin
            opcode = 4'(op); opA = W'(a); opB = '0; satPos = PW'(n);
            #1ns;
            chk(reqOf(op), int'(result), refRes(op, a, 0, n));
          end
        end
      end else begin
        for (int a = 0; a <= ALL; a++) begin
          opcode = 4'(op); opA = W'(a); opB = W'(a ^ 8'h5A); satPos = PW'(a);
          #1ns;
          chk(reqOf(op), int'(result), refRes(op, a, a ^ 8'h5A, a % W));
        end
      end
    end
    @(negedge clk);
    chk("R9 flag untouched by sweeps with valid low", int'(stickyFlag), 0);

    // Each operation's clamp sets the flag
    clearOnly(); apply(0, 8'h70, 8'h70, 0, 1'b1, 1'b0);
    chk("R1 add clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(1, 8'h80, 8'h01, 0, 1'b1, 1'b0);
    chk("R2 sub clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(2, 8'h40, 0, 0, 1'b1, 1'b0);
    chk("R4 doubling clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(3, 8'hF0, 8'h20, 0, 1'b1, 1'b0);
    chk("R5 unsigned add clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(4, 8'h10, 8'h20, 0, 1'b1, 1'b0);
    chk("R5 unsigned sub clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(5, 8'h20, 0, 3, 1'b1, 1'b0);
    chk("R6 signed position clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(6, 8'h80, 0, 3, 1'b1, 1'b0);
    chk("R7 unsigned position clamp sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(7, 8'h70, 0, 1, 1'b1, 1'b0);
    chk("R8 high lane alone sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(8, 8'h08, 0, 2, 1'b1, 1'b0);
    chk("R8 low lane alone sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(9, 8'h70, 8'h70, 0, 1'b1, 1'b0);
    chk("R3 wrap add overflow sets flag", int'(stickyFlag), 1);
    clearOnly(); apply(9, 8'h10, 8'h20, 0, 1'b1, 1'b0);
    chk("R3 wrap add without overflow leaves flag", int'(stickyFlag), 0);

    // Flag sequencing
    clearOnly(); apply(0, 8'h01, 8'h02, 0, 1'b1, 1'b0);
    chk("R9 no clamp keeps flag low", int'(stickyFlag), 0);
    setFlag(); apply(0, 8'h01, 8'h02, 0, 1'b1, 1'b0);
    chk("R9 flag holds after quiet op", int'(stickyFlag), 1);
    apply(10, 0, 0, 0, 1'b0, 1'b0);
    chk("R9 flag holds while idle", int'(stickyFlag), 1);
    clearOnly(); apply(0, 8'h70, 8'h70, 0, 1'b0, 1'b0);
    chk("R9 clamp without valid ignored", int'(stickyFlag), 0);
    setFlag(); apply(0, 8'h70, 8'h70, 0, 1'b1, 1'b1);
    chk("R10 clear beats set", int'(stickyFlag), 0);

    // Unused codes
    setFlag(); apply(12, 8'h70, 8'h70, 0, 1'b1, 1'b0);
    chk("R11 unused code keeps set flag", int'(stickyFlag), 1);
    clearOnly(); apply(15, 8'h80, 8'hFF, 7, 1'b1, 1'b0);
    chk("R11 unused code keeps clear flag", int'(stickyFlag), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule